// File: doc/BRIEF.md
# Shared-Level Registry Directory

This block is the shared second-level word store for a group of cores with private caches. It keeps no sharer list. Each word carries a single state bit. A Valid word holds its data. A Registered word holds, in that same data slot, the id of the core that currently owns the only up-to-date copy. Cores send three kinds of request: read, registration (a write claim) and writeback. The block answers each one with exactly one response routed back to the requester.

A read of a Valid word returns the data. A read of a Registered word returns a redirect that names the owner, and the owner then supplies the data over a path outside this block. A registration overwrites the slot with the requester's id and is acknowledged. A later registration by another core simply replaces that id, and the previous owner is not told. A writeback from the current owner turns the word back to Valid with the written data. A writeback from any other core is dropped.

Every core has a valid/ready request lane. A round-robin arbiter accepts at most one request per cycle. The single response channel is valid/ready too. A response that is held by a low `rsp_ready` blocks every request lane, and the response payload stays frozen until it is taken. A request lane must hold its valid and its fields steady until ready is seen.

Top module: `sld_registry_dir`

## Requirements
- R1: After reset, and after any later reset, every word is Valid and holds zero, no response is pending and no `req_ready` bit is high.
- R2: A read (op 0, op 3 is treated the same way) of a Valid word answers with kind 0 (data) and the word's value in `rsp_data`.
- R3: A registration (op 1) stores the requester's id, zero-extended, in the word, marks the word Registered, and answers with kind 2 (acknowledge) and `rsp_data` equal to zero.
- R4: A registration by a different core replaces the stored id. Only the requester receives a response, and later reads are redirected to the new owner.
- R5: A read of a Registered word answers with kind 1 (redirect) and the owner id in `rsp_data`. This also holds when the owner is the reader.
- R6: A writeback (op 2) from the core whose id is stored in a Registered word makes the word Valid with `req_data` and answers with kind 3 (writeback accepted) and `rsp_data` zero.
- R7: A writeback from a core that is not the owner, or to a Valid word, leaves the word unchanged and answers with kind 4 (writeback dropped) and `rsp_data` zero.
- R8: At most one request is accepted per cycle, only from a lane whose valid is high. The search starts at the lane after the last one granted, so all-lanes-requesting after a grant to lane 2 is served in the order 3, 0, 1, 2.
- R9: A request accepted at a clock edge produces its response at that edge: `rsp_valid` is high in the following cycle, with `rsp_core` equal to the requester's lane. The word update from one request is visible to the request accepted at the next edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, every `req_ready` bit is low and `rsp_core`, `rsp_kind` and `rsp_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CORES | Request valid, one bit per core lane |
| req_ready | output | N_CORES | Request accepted this cycle, one bit per lane |
| req_op | input | 2*N_CORES | Per-lane operation: 0 read, 1 register, 2 writeback, 3 read |
| req_addr | input | ADDR_W*N_CORES | Per-lane word address |
| req_data | input | DATA_W*N_CORES | Per-lane writeback data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken by the destination |
| rsp_core | output | ID_W | Lane the response belongs to |
| rsp_kind | output | 3 | 0 data, 1 redirect, 2 register ack, 3 writeback accepted, 4 writeback dropped |
| rsp_data | output | DATA_W | Word value, owner id, or zero |

## Verification
The assertions assume that request lanes follow the valid/ready rules: a lane's fields are meaningful only while its valid is high, and the response consumer may stall for any number of cycles. They also assume that reset is applied before the first request. The stimulus drives request fields only at falling edges, holds each lane until it is accepted, drops the lane right after the accepting edge, and applies `rsp_ready` low only in the stall test. In the stall test a second lane is kept waiting so that blocking can be observed. Under these conditions the arbitration and stall properties stay within the behaviour the inputs allow.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    OP_READ      = 2'd0,
    OP_REGISTER  = 2'd1,
    OP_WRITEBACK = 2'd2,
    OP_READ_ALT  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RK_DATA     = 3'd0,
    RK_REDIRECT = 3'd1,
    RK_REG_ACK  = 3'd2,
    RK_WB_ACK   = 3'd3,
    RK_WB_DROP  = 3'd4
  } rsp_kind_e;
endpackage

// File: rtl/sld_rr_arb.sv
module sld_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          any
);
  logic [IW-1:0] ptr;

  // Scan from the pointer upward, wrapping; first requester wins (R8)
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (int'(ptr) + i) % N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        grant[idx] = 1'b1;
        grant_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance && any) begin
      ptr <= IW'((int'(grant_idx) + 1) % N);
    end
  end
endmodule

// File: rtl/sld_word_array.sv
module sld_word_array #(
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  localparam int ADDR_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_reg,
  output logic [DATA_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_reg,
  input  logic [DATA_W-1:0] wr_word
);
  // One slot per word: data when Valid, owner id when Registered
  logic [DATA_W-1:0]  slot [N_WORDS];
  logic [N_WORDS-1:0] reg_bit;

  assign rd_reg  = reg_bit[rd_addr];
  assign rd_word = slot[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_bit <= '0;
      for (int i = 0; i < N_WORDS; i++) slot[i] <= '0;
    end else if (wr_en) begin
      reg_bit[wr_addr] <= wr_reg;
      slot[wr_addr]    <= wr_word;
    end
  end
endmodule

// File: rtl/sld_resolve.sv
module sld_resolve
  import sld_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 2
) (
  input  op_e               op,
  input  logic [ID_W-1:0]   core,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cur_reg,
  input  logic [DATA_W-1:0] cur_word,
  output logic              upd,
  output logic              upd_reg,
  output logic [DATA_W-1:0] upd_word,
  output rsp_kind_e         kind,
  output logic [DATA_W-1:0] payload
);
  logic owner_hit;
  assign owner_hit = cur_reg && (cur_word == DATA_W'(core));

  always_comb begin
    upd      = 1'b0;
    upd_reg  = 1'b0;
    upd_word = '0;
    payload  = '0;
    kind     = RK_DATA;
    unique case (op)
      OP_REGISTER: begin
        upd      = 1'b1;
        upd_reg  = 1'b1;
        upd_word = DATA_W'(core);
        kind     = RK_REG_ACK;
      end
      OP_WRITEBACK: begin
        if (owner_hit) begin
          upd      = 1'b1;
          upd_word = wdata;
          kind     = RK_WB_ACK;
        end else begin
          kind     = RK_WB_DROP;
        end
      end
      default: begin
        payload = cur_word;
        kind    = cur_reg ? RK_REDIRECT : RK_DATA;
      end
    endcase
  end
endmodule

// File: rtl/sld_registry_dir.sv
module sld_registry_dir
  import sld_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  localparam int ID_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int ADDR_W = $clog2(N_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES-1:0]        req_valid,
  output logic [N_CORES-1:0]        req_ready,
  input  logic [2*N_CORES-1:0]      req_op,
  input  logic [ADDR_W*N_CORES-1:0] req_addr,
  input  logic [DATA_W*N_CORES-1:0] req_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [ID_W-1:0]           rsp_core,
  output logic [2:0]                rsp_kind,
  output logic [DATA_W-1:0]         rsp_data
);
  logic [N_CORES-1:0] grant;
  logic [ID_W-1:0]    gidx;
  logic               any_req, advance, accept;

  // A held response stalls all lanes
  assign advance   = !rsp_valid || rsp_ready;
  assign accept    = advance && any_req;
  assign req_ready = advance ? grant : '0;

  sld_rr_arb #(.N(N_CORES)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_valid),
    .advance   (advance),
    .grant     (grant),
    .grant_idx (gidx),
    .any       (any_req)
  );

  logic [1:0]        op_l   [N_CORES];
  logic [ADDR_W-1:0] addr_l [N_CORES];
  logic [DATA_W-1:0] data_l [N_CORES];

  for (genvar g = 0; g < N_CORES; g++) begin : g_lane
    assign op_l[g]   = req_op[g*2 +: 2];
    assign addr_l[g] = req_addr[g*ADDR_W +: ADDR_W];
    assign data_l[g] = req_data[g*DATA_W +: DATA_W];
  end

  logic              cur_reg, upd, upd_reg;
  logic [DATA_W-1:0] cur_word, upd_word, payload;
  rsp_kind_e         kind;

  sld_word_array #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) array_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_l[gidx]),
    .rd_reg  (cur_reg),
    .rd_word (cur_word),
    .wr_en   (accept && upd),
    .wr_addr (addr_l[gidx]),
    .wr_reg  (upd_reg),
    .wr_word (upd_word)
  );

  sld_resolve #(.DATA_W(DATA_W), .ID_W(ID_W)) resolve_i (
    .op       (op_e'(op_l[gidx])),
    .core     (gidx),
    .wdata    (data_l[gidx]),
    .cur_reg  (cur_reg),
    .cur_word (cur_word),
    .upd      (upd),
    .upd_reg  (upd_reg),
    .upd_word (upd_word),
    .kind     (kind),
    .payload  (payload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_kind  <= '0;
      rsp_data  <= '0;
    end else if (advance) begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_core <= gidx;
        rsp_kind <= kind;
        rsp_data <= payload;
      end
    end
  end
endmodule

// File: rtl/sld_registry_dir_chk.sv
module sld_registry_dir_chk #(
  parameter int N_CORES = 4,
  parameter int ID_W    = 2,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CORES-1:0] req_valid,
  input logic [N_CORES-1:0] req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [ID_W-1:0]    rsp_core,
  input logic [2:0]         rsp_kind,
  input logic [DATA_W-1:0]  rsp_data
);
  logic [N_CORES-1:0] acc;
  logic [ID_W-1:0]    acc_idx;
  assign acc = req_valid & req_ready;

  always_comb begin
    acc_idx = '0;
    for (int i = 0; i < N_CORES; i++) if (acc[i]) acc_idx = ID_W'(i);
  end

  p_single_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc));

  p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (req_ready == '0));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_core) && $stable(rsp_kind) && $stable(rsp_data)));

  p_accept_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != '0) |=> (rsp_valid && rsp_core == $past(acc_idx)));

  p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind <= 3'd4));
endmodule

bind sld_registry_dir sld_registry_dir_chk #(
  .N_CORES (N_CORES),
  .ID_W    (ID_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_core  (rsp_core),
  .rsp_kind  (rsp_kind),
  .rsp_data  (rsp_data)
);

// File: tb/sld_registry_dir_tb_top.sv
`timescale 1ns/1ps
module sld_registry_dir_tb_top;
  localparam int NC = 4, NW = 16, DW = 32, AW = 4, IW = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NC-1:0]      req_valid = '0;
  logic [NC-1:0]      req_ready;
  logic [2*NC-1:0]    req_op = '0;
  logic [AW*NC-1:0]   req_addr = '0;
  logic [DW*NC-1:0]   req_data = '0;
  logic               rsp_valid;
  logic               rsp_ready = 1'b1;
  logic [IW-1:0]      rsp_core;
  logic [2:0]         rsp_kind;
  logic [DW-1:0]      rsp_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sld_registry_dir #(.N_CORES(NC), .N_WORDS(NW), .DATA_W(DW)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_lane(input int c, input logic [1:0] op, input logic [3:0] a,
                          input logic [31:0] d);
    req_op[c*2 +: 2]     = op;
    req_addr[c*AW +: AW] = a;
    req_data[c*DW +: DW] = d;
    req_valid[c]         = 1'b1;
  endtask

  // {tag, core, op, addr, wdata, kind, expected data}
  localparam logic [78:0] VEC [0:16] = '{
    {4'd2, 2'd1, 2'd0, 4'd3,  32'h0,        3'd0, 32'h0},        // R2 read of reset word
    {4'd3, 2'd1, 2'd1, 4'd3,  32'h0,        3'd2, 32'h0},        // R3 core1 registers
    {4'd5, 2'd2, 2'd0, 4'd3,  32'h0,        3'd1, 32'h1},        // R5 redirect to 1
    {4'd4, 2'd2, 2'd1, 4'd3,  32'h0,        3'd2, 32'h0},        // R4 core2 takes over
    {4'd4, 2'd0, 2'd0, 4'd3,  32'h0,        3'd1, 32'h2},        // R4 redirect to 2
    {4'd7, 2'd1, 2'd2, 4'd3,  32'hAAAA,     3'd4, 32'h0},        // R7 stale owner writeback
    {4'd7, 2'd0, 2'd0, 4'd3,  32'h0,        3'd1, 32'h2},        // R7 word unchanged
    {4'd6, 2'd2, 2'd2, 4'd3,  32'h1234,     3'd3, 32'h0},        // R6 owner writeback
    {4'd6, 2'd3, 2'd0, 4'd3,  32'h0,        3'd0, 32'h1234},     // R6 word Valid again
    {4'd7, 2'd3, 2'd2, 4'd7,  32'h55,       3'd4, 32'h0},        // R7 writeback to Valid word
    {4'd7, 2'd0, 2'd3, 4'd7,  32'h0,        3'd0, 32'h0},        // R7 unchanged, op 3 reads
    {4'd3, 2'd0, 2'd1, 4'd15, 32'h0,        3'd2, 32'h0},        // R3 top word
    {4'd5, 2'd3, 2'd0, 4'd15, 32'h0,        3'd1, 32'h0},        // R5 owner id zero
    {4'd6, 2'd0, 2'd2, 4'd15, 32'hFFFFFFFF, 3'd3, 32'h0},        // R6
    {4'd2, 2'd1, 2'd0, 4'd15, 32'h0,        3'd0, 32'hFFFFFFFF}, // R2 all-ones data
    {4'd3, 2'd3, 2'd1, 4'd0,  32'h0,        3'd2, 32'h0},        // R3 word 0
    {4'd5, 2'd3, 2'd0, 4'd0,  32'h0,        3'd1, 32'h3}         // R5 owner reads own word
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: idle after reset
    chk("R1 idle", {rsp_valid, req_ready}, '0);

    // R9 response one edge after accept, routed to the requester
    foreach (VEC[i]) begin
      logic [78:0] v;
      v = VEC[i];
      @(negedge clk);
      set_lane(int'(v[74:73]), v[72:71], v[70:67], v[66:35]);
      @(posedge clk); #1;
      req_valid = '0;
      @(negedge clk);
      chk($sformatf("R%0d/R9 vector %0d", v[78:75], i),
          {rsp_valid, 2'(rsp_core), rsp_kind, rsp_data},
          {1'b1, v[74:73], v[34:32], v[31:0]});
    end

    // R8: lane 2 alone, then all lanes: expect 3,0,1,2
    @(negedge clk);
    set_lane(2, 2'd0, 4'd1, 32'h0);
    @(posedge clk); #1;
    req_valid = '0;
    @(negedge clk);
    set_lane(3, 2'd0, 4'd3, 32'h0);
    set_lane(0, 2'd0, 4'd7, 32'h0);
    set_lane(1, 2'd0, 4'd15, 32'h0);
    set_lane(2, 2'd0, 4'd0, 32'h0);
    #1;
    for (int k = 0; k < 4; k++) begin
      int e;
      e = (k + 3) % 4;
      chk("R8 ready one-hot", 64'(req_ready), 64'(1 << e));
      @(posedge clk); #1;
      req_valid[e] = 1'b0;
      @(negedge clk);
      chk("R8 grant order", 64'(rsp_core), 64'(e));
    end

    // R10: stalled response blocks lanes and holds
    @(negedge clk);
    rsp_ready = 1'b0;
    set_lane(1, 2'd0, 4'd3, 32'h0);
    @(posedge clk); #1;
    req_valid = '0;
    set_lane(0, 2'd0, 4'd15, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held", {rsp_valid, 2'(rsp_core), rsp_kind, rsp_data, req_ready},
          {1'b1, 2'd1, 3'd0, 32'h1234, 4'b0000});
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = '0;
    @(negedge clk);
    chk("R10 released", {rsp_valid, 2'(rsp_core), rsp_kind, rsp_data},
        {1'b1, 2'd0, 3'd0, 32'hFFFFFFFF});
    @(negedge clk);
    chk("R9 no request no response", 64'(rsp_valid), 64'd0);

    // R1: reset again clears the Registered word 0
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 idle after re-reset", {rsp_valid, req_ready}, '0);
    set_lane(1, 2'd0, 4'd0, 32'h0);
    @(posedge clk); #1;
    req_valid = '0;
    @(negedge clk);
    chk("R1 word zero Valid", {rsp_valid, rsp_kind, rsp_data}, {1'b1, 3'd0, 32'h0});

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule